// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block is the home controller for a group of memory lines in a directory-coherent multiprocessor. For each line it stores a presence mask with one bit per processor, plus a flag saying whether one processor owns the line dirty, and which processor that is. Processors send it read or write (ownership) requests. Instead of broadcasting on a snooped bus, the block sends point-to-point invalidate or recall messages only to the processors whose presence bit is set. It collects their acknowledgements, updates the entry and then issues a grant.

The block runs one transaction at a time. A request is accepted when `reqReady` is high. From acceptance until the cycle after the grant, `reqReady` stays low, so a request to any line, including the line in flight, is held back until the current transaction completes. Messages leave one per cycle in ascending processor order. A read of a line that another processor holds dirty first recalls the line from that owner. After the recall the owner keeps a clean shared copy. The processor count and the line count are parameters. The mask width follows the processor count, for example 32 processors give a 32-bit mask per line. Routing, data movement and the caches themselves lie outside this block.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every line is clean with an empty presence mask, `reqReady` is 1, and `invValid` and `grantValid` are 0.
- R2: A read of a line that no other processor holds dirty sends no message. Its grant appears in the cycle after acceptance, and the requester's presence bit is then set.
- R3: A write sends one invalidate (`invRecall`=0, `invLine` = requested line) to each processor whose presence bit is set, except the requester. The messages go out exactly once each, in ascending processor id, on consecutive cycles starting the cycle after acceptance. A processor whose bit is clear is never addressed.
- R4: The grant of a request that sent messages is withheld until every addressed processor has acknowledged. It appears in the cycle after the last acknowledgement, provided all messages have been sent.
- R5: After a write grant, the line's presence mask holds only the writer's bit and the line is dirty-owned by the writer.
- R6: A read of a line held dirty by another processor sends exactly one recall (`invRecall`=1) to the owner, and nothing to anyone else. Once the read is granted the line is clean and shared by the owner and the reader.
- R7: A read or write by the current dirty owner of its own line sends no message, and the grant appears in the cycle after acceptance.
- R8: `reqReady` is 0 from the cycle after acceptance through the grant cycle and returns to 1 in the cycle after the grant. Only one transaction is in flight at a time.
- R9: `grantProc`, `grantLine` and `grantWrite` repeat the accepted request's processor, line and type.
- R10: Each line's entry is independent. A transaction changes only the entry of the line it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqProc | input | PW | Requesting processor id |
| reqLine | input | LW | Requested line index |
| reqWrite | input | 1 | 1 = write/ownership, 0 = read |
| invValid | output | 1 | Message to a single processor this cycle |
| invTarget | output | PW | Processor addressed by the message |
| invLine | output | LW | Line the message concerns |
| invRecall | output | 1 | 1 = recall dirty data and keep a shared copy, 0 = invalidate |
| ackValid | input | 1 | Acknowledgement from a processor |
| ackProc | input | PW | Processor sending the acknowledgement |
| grantValid | output | 1 | One-cycle grant pulse |
| grantProc | output | PW | Processor granted |
| grantLine | output | LW | Line granted |
| grantWrite | output | 1 | Type of the granted request |

## Verification
Each result has a fixed latency. With no message to send, the grant is due one cycle after acceptance. The k-th message (counting from zero) is due k+1 cycles after acceptance. With messages outstanding, the grant is due one cycle after the cycle in which the last acknowledgement was driven. The bench keeps a cycle index relative to the acceptance edge and samples every output on the falling edge. It checks each message and each grant against the exact cycle predicted by its own directory model. The delay before each acknowledgement varies, so acknowledgements overlap the send sequence as well as arriving after it.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } dirState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch request and build target set
    logic sendOne;   // issue message to lowest pending target
    logic commit;    // update entry and grant
  } dirStrobe_t;

endpackage

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       pendSend,
  input  logic       pendAck,
  output logic       reqReady,
  output dirStrobe_t strb
);

  dirState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    reqReady  = (state == ST_IDLE);
    if (state == ST_IDLE) begin
      strb.capture = reqValid;
      if (reqValid) stateNext = ST_RUN;
    end else if (pendSend) begin
      strb.sendOne = 1'b1;
    end else if (!pendAck) begin
      strb.commit = 1'b1;
      stateNext   = ST_IDLE;
    end
  end

  // R8
  hold_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  // R8
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |=> reqReady);

  // R4
  grant_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |-> (!pendAck && !pendSend));

endmodule

// File: rtl/coh_dir_data.sv
module coh_dir_data
  import coh_dir_pkg::*;
#(
  parameter int NUM_PROC  = 4,
  parameter int NUM_LINES = 8,
  localparam int PW = $clog2(NUM_PROC),
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dirStrobe_t    strb,
  input  logic [PW-1:0] reqProc,
  input  logic [LW-1:0] reqLine,
  input  logic          reqWrite,
  input  logic          ackValid,
  input  logic [PW-1:0] ackProc,
  output logic          pendSend,
  output logic          pendAck,
  output logic [PW-1:0] invTarget,
  output logic          invRecall,
  output logic [PW-1:0] curProc,
  output logic [LW-1:0] curLine,
  output logic          curWrite
);

  typedef logic [NUM_PROC-1:0] procMask_t;

  // directory storage, one entry per line
  logic [NUM_LINES-1:0][NUM_PROC-1:0] presAll;
  logic [NUM_LINES-1:0]               dirtyAll;
  logic [NUM_LINES-1:0][PW-1:0]       ownerAll;

  procMask_t sendMask, ackPend;
  procMask_t curBit, lowBit, ackBit, reqBit, initMask;
  procMask_t selPres;
  logic      selDirty, initRecall;
  logic [PW-1:0] selOwner;

  function automatic logic [PW-1:0] lowIdx(input procMask_t m);
    logic [PW-1:0] idx;
    idx = '0;
    for (int i = NUM_PROC - 1; i >= 0; i--)
      if (m[i]) idx = PW'(i);
    return idx;
  endfunction

  assign selPres  = presAll[reqLine];
  assign selDirty = dirtyAll[reqLine];
  assign selOwner = ownerAll[reqLine];
  assign reqBit   = procMask_t'(1) << reqProc;
  assign curBit   = procMask_t'(1) << curProc;
  assign ackBit   = ackValid ? (procMask_t'(1) << ackProc) : '0;

  assign invTarget = lowIdx(sendMask);
  assign lowBit    = procMask_t'(1) << invTarget;
  assign pendSend  = |sendMask;
  assign pendAck   = |ackPend;

  // target set for the request being accepted
  always_comb begin
    initMask   = '0;
    initRecall = 1'b0;
    if (reqWrite) begin
      initMask = selPres & ~reqBit;
    end else if (selDirty && (selOwner != reqProc)) begin
      initMask   = procMask_t'(1) << selOwner;
      initRecall = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curProc   <= '0;
      curLine   <= '0;
      curWrite  <= 1'b0;
      invRecall <= 1'b0;
      sendMask  <= '0;
      ackPend   <= '0;
    end else if (strb.capture) begin
      curProc   <= reqProc;
      curLine   <= reqLine;
      curWrite  <= reqWrite;
      invRecall <= initRecall;
      sendMask  <= initMask;
      ackPend   <= '0;
    end else begin
      if (strb.sendOne) sendMask <= sendMask & ~lowBit;
      ackPend <= (ackPend | (strb.sendOne ? lowBit : '0)) & ~ackBit;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        presAll[g]  <= '0;
        dirtyAll[g] <= 1'b0;
        ownerAll[g] <= '0;
      end else if (strb.commit && (curLine == LW'(g))) begin
        if (curWrite) begin
          presAll[g]  <= curBit;
          dirtyAll[g] <= 1'b1;
          ownerAll[g] <= curProc;
        end else begin
          presAll[g] <= presAll[g] | curBit;
          if (invRecall) dirtyAll[g] <= 1'b0;
        end
      end
    end
  end

  // R4
  ack_awaited_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> (ackPend[ackProc] || (strb.sendOne && invTarget == ackProc)));

  // R3
  no_self_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sendOne |-> (invTarget != curProc));

  // R5
  sole_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commit && curWrite) |=> (presAll[curLine] == curBit && dirtyAll[curLine]));

  // R6
  recall_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commit && !curWrite && invRecall) |=> (!dirtyAll[curLine] && $countones(presAll[curLine]) == 2));

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
  import coh_dir_pkg::*;
#(
  parameter int NUM_PROC  = 4,
  parameter int NUM_LINES = 8,
  localparam int PW = $clog2(NUM_PROC),
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [PW-1:0] reqProc,
  input  logic [LW-1:0] reqLine,
  input  logic          reqWrite,
  output logic          invValid,
  output logic [PW-1:0] invTarget,
  output logic [LW-1:0] invLine,
  output logic          invRecall,
  input  logic          ackValid,
  input  logic [PW-1:0] ackProc,
  output logic          grantValid,
  output logic [PW-1:0] grantProc,
  output logic [LW-1:0] grantLine,
  output logic          grantWrite
);

  dirStrobe_t strb;
  logic pendSend, pendAck;
  logic [PW-1:0] curProc;
  logic [LW-1:0] curLine;
  logic curWrite;

  coh_dir_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .pendSend(pendSend), .pendAck(pendAck),
    .reqReady(reqReady), .strb(strb)
  );

  coh_dir_data #(.NUM_PROC(NUM_PROC), .NUM_LINES(NUM_LINES)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .reqProc(reqProc), .reqLine(reqLine), .reqWrite(reqWrite),
    .ackValid(ackValid), .ackProc(ackProc),
    .pendSend(pendSend), .pendAck(pendAck),
    .invTarget(invTarget), .invRecall(invRecall),
    .curProc(curProc), .curLine(curLine), .curWrite(curWrite)
  );

  assign invValid   = strb.sendOne;
  assign invLine    = curLine;
  assign grantValid = strb.commit;
  assign grantProc  = curProc;
  assign grantLine  = curLine;
  assign grantWrite = curWrite;

endmodule

// File: tb/sim_coh_home_dir.sv
module sim_coh_home_dir;

  localparam int NP = 4;
  localparam int NL = 8;
  localparam int PW = $clog2(NP);
  localparam int LW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, ackValid = 1'b0;
  logic [PW-1:0] reqProc = '0, ackProc = '0;
  logic [LW-1:0] reqLine = '0;
  logic reqReady, invValid, invRecall, grantValid, grantWrite;
  logic [PW-1:0] invTarget, grantProc;
  logic [LW-1:0] invLine, grantLine;

  always #2 clk = ~clk;

  coh_home_dir #(.NUM_PROC(NP), .NUM_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqProc(reqProc), .reqLine(reqLine), .reqWrite(reqWrite),
    .invValid(invValid), .invTarget(invTarget), .invLine(invLine),
    .invRecall(invRecall), .ackValid(ackValid), .ackProc(ackProc),
    .grantValid(grantValid), .grantProc(grantProc), .grantLine(grantLine),
    .grantWrite(grantWrite)
  );

  int vectors = 0;
  int misses  = 0;

  // bench directory model
  logic [NP-1:0] mPres [NL];
  logic          mDirty [NL];
  int            mOwner [NL];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runReq(input int p, input int l, input bit w, input int gap);
    int expSeq[NP];
    int nExp = 0, nSeen = 0, lastAckT = -1;
    int q[NP];
    int qHead = 0, qTail = 0;
    bit expRecall = 1'b0, granted = 1'b0;
    // expected targets, ascending id
    for (int i = 0; i < NP; i++) begin
      if (w) begin
        if (mPres[l][i] && i != p) begin expSeq[nExp] = i; nExp++; end
      end else if (mDirty[l] && mOwner[l] != p && mOwner[l] == i) begin
        expSeq[nExp] = i; nExp++; expRecall = 1'b1;
      end
    end
    @(negedge clk);
    chk(reqReady == 1'b1, "R8", "ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqProc = PW'(p); reqLine = LW'(l); reqWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
    for (int t = 0; t < 60; t++) begin
      if (t == 0) chk(reqReady == 1'b0, "R8", "ready while busy", int'(reqReady), 0);
      ackValid = 1'b0;
      if (invValid) begin
        chk(t == nSeen, "R3", "message cycle", t, nSeen);
        chk(nSeen < nExp && int'(invTarget) == expSeq[nSeen], w ? "R3" : "R6",
            "message target", int'(invTarget), nSeen < nExp ? expSeq[nSeen] : -1);
        chk(invRecall == expRecall, w ? "R3" : "R6", "recall flag", int'(invRecall), int'(expRecall));
        chk(int'(invLine) == l, "R3", "message line", int'(invLine), l);
      end
      if (grantValid) begin
        chk(nSeen == nExp, "R4", "messages before grant", nSeen, nExp);
        chk(qHead == qTail, "R4", "acks before grant", qTail - qHead, 0);
        chk(t == lastAckT + 1, nExp == 0 ? (w ? "R7" : "R2") : "R4", "grant cycle", t, lastAckT + 1);
        chk(int'(grantProc) == p && int'(grantLine) == l && grantWrite == w, "R9",
            "grant fields", int'({grantProc, grantLine, grantWrite}), int'({PW'(p), LW'(l), w}));
        granted = 1'b1;
        break;
      end
      // acknowledge an earlier message, then queue the new one
      if (qHead != qTail && (t - lastAckT) > gap) begin
        ackValid = 1'b1; ackProc = PW'(q[qHead % NP]); qHead++; lastAckT = t;
      end
      if (invValid) begin q[qTail % NP] = int'(invTarget); qTail++; nSeen++; end
      @(negedge clk);
      if (t > 0) chk(grantValid || reqReady == 1'b0, "R8", "ready stays low", int'(reqReady), 0);
    end
    ackValid = 1'b0;
    chk(granted, "R4", "grant seen", int'(granted), 1);
    @(negedge clk);
    chk(reqReady == 1'b1, "R8", "ready after grant", int'(reqReady), 1);
    // model update
    if (w) begin
      mPres[l] = '0; mPres[l][p] = 1'b1; mDirty[l] = 1'b1; mOwner[l] = p;
    end else begin
      mPres[l][p] = 1'b1;
      if (expRecall) mDirty[l] = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NL; i++) begin mPres[i] = '0; mDirty[i] = 1'b0; mOwner[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1", "reset ready", int'(reqReady), 1);
    chk(invValid == 1'b0, "R1", "reset message", int'(invValid), 0);
    chk(grantValid == 1'b0, "R1", "reset grant", int'(grantValid), 0);
    // R1 R2 sweep: every processor reads every line, no messages
    for (int l = 0; l < NL; l++)
      for (int p = 0; p < NP; p++) runReq(p, l, 1'b0, 0);
    // R3 R4 R5: write with three sharers, slow acks
    runReq(0, 0, 1'b1, 3);
    // R6: recall from owner, then both share cleanly
    runReq(1, 0, 1'b0, 1);
    // R3: third writer invalidates both sharers
    runReq(2, 0, 1'b1, 0);
    // R7: owner re-read and re-write, no messages
    runReq(2, 0, 1'b0, 0);
    runReq(2, 0, 1'b1, 0);
    // R10: other lines untouched by line 0 traffic
    runReq(3, 1, 1'b1, 2);
    runReq(0, 2, 1'b0, 0);
    runReq(1, 1, 1'b0, 0);
    // sweep of mixed traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      runReq(int'(lfsr[1:0]), int'(lfsr[4:2]), lfsr[6] & lfsr[7], int'(lfsr[9:8]));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule